// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block collects maskable interrupt requests for a small processor. Each source has a control register. The register holds a 3-bit priority level, a request flag and, for the two pin-driven sources, an edge polarity bit. Internal sources raise their flag on a one-cycle event pulse. The two external pins pass through a two-flop synchronizer and raise their flag on the edge chosen by polarity. Every cycle, the controller picks the pending, enabled source with the highest level. It presents that source's number and level to the processor. It drives the interrupt request line only when the global enable input is high and the winner's level is strictly above the processor's current priority level.

Software reaches the registers over a plain synchronous bus. Every access completes in one cycle and is never back-pressured, so the bus has no valid/ready pair. Read data appears on the cycle after the read. Address 0 is the acknowledge location. A read there returns the winner's number and level and clears that source's flag at the same edge. It does this whether or not an interrupt is being taken, so software must not read it casually. Writing a new polarity to a pin source can itself raise that source's flag, so software should set the level to 0, change the polarity, clear the flag, and then restore the level.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Source i (0 to NUM_SRC-1) is controlled by the register at bus address i+1, with its level in bits 2:0. A level of 0 keeps a pending source out of arbitration, and levels 1 to 7 let it compete.
- R2: Bit 3 of a control register is the request flag. An event sampled at a clock edge sets it from that edge on. A write with bit 3 = 0 clears it, and a write with bit 3 = 1 leaves it unchanged. If an event and a clear reach the same edge, the event wins.
- R3: Sources 0 and 1 are fed by ext_pin[0] and ext_pin[1] through two synchronizer flops. Bit 4 selects the active edge: 1 for rising, 0 for falling. A pin change applied before edge k sets the flag at edge k+2.
- R4: A write that changes bit 4 of a pin source sets that source's flag when the synchronized pin already sits at the newly active level (high for rising, low for falling). This happens even if the same write carries bit 3 = 0.
- R5: The winner is the pending source with a nonzero level that has the highest level, with ties going to the lowest index. irq_num reports index+1 and irq_lvl reports its level. Both are 0 when nothing qualifies.
- R6: irq is 1 exactly when gie is 1, a winner exists, and the winner's level is strictly greater than cpu_ipl.
- R7: A read of address 0 returns, on the next cycle, the winner's level in bits 7:5 and its number in bits 3:0, with all other bits 0. It clears the winner's flag at the same edge, regardless of gie and cpu_ipl. With no winner it returns 0 and clears nothing.
- R8: A read of address i+1 returns {3'b0, polarity, flag, level} on the next cycle. The polarity bit reads 0 for internal sources. Addresses above NUM_SRC read 0, and bus_rdata holds its value between reads.
- R9: During and after reset, all levels, flags, polarity bits, bus_rdata, irq, irq_num and irq_lvl are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_pin | input | NUM_EXT | Asynchronous external interrupt pins (sources 0..NUM_EXT-1) |
| int_evt | input | NUM_SRC-NUM_EXT | One-cycle event pulses for internal sources NUM_EXT.. |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register address (0 = acknowledge) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after a read |
| gie | input | 1 | Global interrupt enable |
| cpu_ipl | input | 3 | Processor's current interrupt priority level |
| irq | output | 1 | Interrupt request to the processor |
| irq_num | output | NUM_W | Winning source number (index+1), 0 if none |
| irq_lvl | output | 3 | Winning source level, 0 if none |

## Verification
Results fall due at different times. An internal event pulse or a register write shows up in the flags, irq and irq_num right after the edge that samples it. A pin change needs three edges. Read data and the clearing effect of an acknowledge both land at the edge that samples the read. The bench drives inputs at the falling edge and advances a cycle-stepped model at each rising edge, using the inputs held across that edge. It compares every output at the following falling edge. Directed checks count the edges explicitly, including the check that a pin source is still quiet after two edges and raised after the third.

// File: rtl/pic_pkg.sv
`timescale 1ns/100ps
package pic_pkg;
  localparam int LVL_W       = 3;
  localparam int CTL_REQ_BIT = 3;
  localparam int CTL_POL_BIT = 4;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/pic_pin_sync.sv
`timescale 1ns/100ps
module pic_pin_sync #(
  parameter int NUM_EXT = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EXT-1:0] pin_in,
  input  logic [NUM_EXT-1:0] pol,
  output logic [NUM_EXT-1:0] pin_lvl,
  output logic [NUM_EXT-1:0] pin_edge
);
  logic [NUM_EXT-1:0] s1_q, s2_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= pin_in;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign pin_lvl = s2_q;

  for (genvar g = 0; g < NUM_EXT; g++) begin : g_edge
    assign pin_edge[g] = pol[g] ? (s2_q[g] & ~prev_q[g]) : (~s2_q[g] & prev_q[g]);

    // R3: with the polarity unchanged, two active edges cannot come back to back
    a_r3_edge_spaced: assert property (@(posedge clk) disable iff (!rst_n)
      pin_edge[g] |=> (pol[g] != $past(pol[g])) || !pin_edge[g]);
  end
endmodule

// File: rtl/pic_src_slot.sv
`timescale 1ns/100ps
module pic_src_slot import pic_pkg::*; #(
  parameter bit IS_EXT = 1'b0,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              hw_evt,
  input  logic              pin_lvl,
  input  logic              ack_clr,
  output lvl_t              lvl_o,
  output logic              req_o,
  output logic              pol_o,
  output logic [DATA_W-1:0] ctl_o
);
  lvl_t lvl_q;
  logic req_q, pol_q;
  logic pol_new, pol_side, sw_clr;

  always_comb begin
    pol_new = pol_q;
    if (IS_EXT && wr_en) pol_new = wdata[CTL_POL_BIT];
    pol_side = IS_EXT && wr_en && (pol_new != pol_q) && (pol_new ? pin_lvl : !pin_lvl);
    sw_clr   = wr_en && !wdata[CTL_REQ_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      req_q <= 1'b0;
      pol_q <= 1'b0;
    end else begin
      if (wr_en) lvl_q <= wdata[LVL_W-1:0];
      pol_q <= pol_new;
      if (hw_evt || pol_side)     req_q <= 1'b1;
      else if (sw_clr || ack_clr) req_q <= 1'b0;
    end
  end

  always_comb begin
    ctl_o = '0;
    ctl_o[LVL_W-1:0]   = lvl_q;
    ctl_o[CTL_REQ_BIT] = req_q;
    ctl_o[CTL_POL_BIT] = pol_q;
  end

  assign lvl_o = lvl_q;
  assign req_o = req_q;
  assign pol_o = pol_q;

  // R2: an event always leaves the flag set
  a_r2_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
    hw_evt |=> req_q);
  // R7: an acknowledge clear with no competing set leaves the flag low
  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_clr && !hw_evt && !pol_side) |=> !req_q);
  // R1: a write lands its level field
  a_r1_lvl_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> lvl_q == $past(wdata[LVL_W-1:0]));
  // R4: a polarity write onto an already active level raises the flag
  a_r4_pol_side: assert property (@(posedge clk) disable iff (!rst_n)
    pol_side |=> req_q);
endmodule

// File: rtl/pic_arbiter.sv
`timescale 1ns/100ps
module pic_arbiter import pic_pkg::*; #(
  parameter int NUM_SRC = 8,
  parameter int IDX_W   = $clog2(NUM_SRC)
) (
  input  lvl_t [NUM_SRC-1:0] lvl,
  input  logic [NUM_SRC-1:0] req,
  output logic               win_valid,
  output logic [IDX_W-1:0]   win_idx,
  output lvl_t               win_lvl
);
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_lvl   = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (req[i] && (lvl[i] > win_lvl)) begin
        win_valid = 1'b1;
        win_idx   = IDX_W'(i);
        win_lvl   = lvl[i];
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
`timescale 1ns/100ps
module prio_irq_ctrl import pic_pkg::*; #(
  parameter int NUM_SRC = 8,
  parameter int NUM_EXT = 2,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 8,
  parameter int NUM_W   = $clog2(NUM_SRC + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_EXT-1:0]         ext_pin,
  input  logic [NUM_SRC-NUM_EXT-1:0] int_evt,
  input  logic                       bus_sel,
  input  logic                       bus_wr,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  input  logic                       gie,
  input  logic [LVL_W-1:0]           cpu_ipl,
  output logic                       irq,
  output logic [NUM_W-1:0]           irq_num,
  output logic [LVL_W-1:0]           irq_lvl
);
  localparam int IDX_W = $clog2(NUM_SRC);

  logic [NUM_EXT-1:0] pin_lvl, pin_edge, pin_pol;
  lvl_t [NUM_SRC-1:0] slot_lvl;
  logic [NUM_SRC-1:0] slot_req, slot_pol;
  logic [NUM_SRC-1:0][DATA_W-1:0] slot_ctl;
  logic [NUM_SRC-1:0] wr_vec, evt_vec, plv_vec, clr_vec;

  logic             rd_en, ack_rd;
  logic             win_valid;
  logic [IDX_W-1:0] win_idx;
  lvl_t             win_lvl;
  logic [NUM_W-1:0] win_num;
  logic [DATA_W-1:0] ack_word, rd_word, rdata_q;

  assign rd_en  = bus_sel && !bus_wr;
  assign ack_rd = rd_en && (bus_addr == '0);

  pic_pin_sync #(.NUM_EXT(NUM_EXT)) u_pins (
    .clk(clk), .rst_n(rst_n), .pin_in(ext_pin), .pol(pin_pol),
    .pin_lvl(pin_lvl), .pin_edge(pin_edge)
  );
  assign pin_pol = slot_pol[NUM_EXT-1:0];

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign wr_vec[i]  = bus_sel && bus_wr && (bus_addr == ADDR_W'(i + 1));
    assign clr_vec[i] = ack_rd && win_valid && (win_idx == IDX_W'(i));
    if (i < NUM_EXT) begin : g_ext
      assign evt_vec[i] = pin_edge[i];
      assign plv_vec[i] = pin_lvl[i];
    end else begin : g_int
      assign evt_vec[i] = int_evt[i - NUM_EXT];
      assign plv_vec[i] = 1'b0;
    end

    pic_src_slot #(.IS_EXT(i < NUM_EXT), .DATA_W(DATA_W)) u_slot (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_vec[i]), .wdata(bus_wdata),
      .hw_evt(evt_vec[i]), .pin_lvl(plv_vec[i]), .ack_clr(clr_vec[i]),
      .lvl_o(slot_lvl[i]), .req_o(slot_req[i]), .pol_o(slot_pol[i]),
      .ctl_o(slot_ctl[i])
    );

    // R5: no enabled pending source outranks the reported winner
    a_r5_no_higher: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_req[i] && slot_lvl[i] != '0) |-> (win_valid && slot_lvl[i] <= win_lvl));
    // R5: on a tied level the lowest index is chosen
    a_r5_tie_low: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_req[i] && slot_lvl[i] != '0 && slot_lvl[i] == win_lvl) |-> (win_idx <= IDX_W'(i)));
  end

  pic_arbiter #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_arb (
    .lvl(slot_lvl), .req(slot_req),
    .win_valid(win_valid), .win_idx(win_idx), .win_lvl(win_lvl)
  );

  assign win_num = NUM_W'(win_idx) + NUM_W'(1);

  always_comb begin
    ack_word = '0;
    if (win_valid) begin
      ack_word[NUM_W-1:0]          = win_num;
      ack_word[DATA_W-1 -: LVL_W]  = win_lvl;
    end
  end

  always_comb begin
    rd_word = '0;
    if (bus_addr == '0) rd_word = ack_word;
    else begin
      for (int i = 0; i < NUM_SRC; i++)
        if (bus_addr == ADDR_W'(i + 1)) rd_word = slot_ctl[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_word;
  end
  assign bus_rdata = rdata_q;

  assign irq_num = win_valid ? win_num : '0;
  assign irq_lvl = win_lvl;
  assign irq     = gie && win_valid && (win_lvl > cpu_ipl);

  // R6: a raised request always outranks the processor level
  a_r6_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (gie && irq_lvl > cpu_ipl && irq_num != '0));
  // R7: acknowledging with nothing pending yields a zero word
  a_r7_empty_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && !win_valid) |=> (bus_rdata == '0));
endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
`timescale 1ns/100ps
module prio_irq_ctrl_tb_top;
  localparam int NS = 8, NE = 2, NI = 6, AW = 4, DW = 8, NW = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic [NE-1:0] ext_pin = '0;
  logic [NI-1:0] int_evt = '0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic gie = 1'b0;
  logic [2:0] cpu_ipl = '0;
  logic irq;
  logic [NW-1:0] irq_num;
  logic [2:0] irq_lvl;

  prio_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .int_evt(int_evt),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gie(gie),
    .cpu_ipl(cpu_ipl), .irq(irq), .irq_num(irq_num), .irq_lvl(irq_lvl)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [2:0] m_lvl [NS];
  bit m_req [NS];
  bit m_pol [NE];
  bit m_s1 [NE], m_s2 [NE], m_prev [NE];
  logic [DW-1:0] m_rd;

  task automatic check(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic void find_win(output bit v, output int wi, output int wl);
    v = 0; wi = 0; wl = 0;
    for (int i = 0; i < NS; i++)
      if (m_req[i] && int'(m_lvl[i]) > wl) begin v = 1; wi = i; wl = int'(m_lvl[i]); end
  endfunction

  function automatic logic [DW-1:0] ctl_of(int k);
    logic [DW-1:0] w = '0;
    w[2:0] = m_lvl[k];
    w[3]   = m_req[k];
    w[4]   = (k < NE) ? m_pol[k] : 1'b0;
    return w;
  endfunction

  task automatic model_update();
    bit v, rd, ack;
    int wi, wl, a;
    bit setv [NS];
    bit clrv [NS];
    find_win(v, wi, wl);
    rd  = bus_sel && !bus_wr;
    a   = int'(bus_addr);
    ack = rd && (a == 0);
    for (int i = 0; i < NS; i++) begin setv[i] = 0; clrv[i] = 0; end
    for (int i = 0; i < NE; i++)
      setv[i] = m_pol[i] ? (m_s2[i] && !m_prev[i]) : (!m_s2[i] && m_prev[i]);
    for (int j = 0; j < NI; j++) setv[NE + j] = int_evt[j];
    if (ack && v) clrv[wi] = 1;
    if (rd) begin
      if (ack) m_rd = v ? {wl[2:0], 1'b0, 4'(wi + 1)} : '0;
      else if (a >= 1 && a <= NS) m_rd = ctl_of(a - 1);
      else m_rd = '0;
    end
    if (bus_sel && bus_wr && a >= 1 && a <= NS) begin
      int k = a - 1;
      if (!bus_wdata[3]) clrv[k] = 1;
      if (k < NE && bus_wdata[4] != m_pol[k] && (bus_wdata[4] ? m_s2[k] : !m_s2[k])) setv[k] = 1;
      m_lvl[k] = bus_wdata[2:0];
      if (k < NE) m_pol[k] = bus_wdata[4];
    end
    for (int i = 0; i < NS; i++)
      if (setv[i]) m_req[i] = 1; else if (clrv[i]) m_req[i] = 0;
    for (int i = 0; i < NE; i++) begin
      m_prev[i] = m_s2[i]; m_s2[i] = m_s1[i]; m_s1[i] = ext_pin[i];
    end
  endtask

  task automatic compare_model();
    bit v; int wi, wl;
    find_win(v, wi, wl);
    check("R6 irq", int'(irq), int'(gie && v && wl > int'(cpu_ipl)));
    check("R5 irq_num", int'(irq_num), v ? wi + 1 : 0);
    check("R5 irq_lvl", int'(irq_lvl), wl);
    check("R8 bus_rdata", int'(bus_rdata), int'(m_rd));
  endtask

  task automatic step();
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare_model();
  endtask

  task automatic wr(int a, int d);
    bus_sel = 1; bus_wr = 1; bus_addr = AW'(a); bus_wdata = DW'(d);
    step();
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(int a);
    bus_sel = 1; bus_wr = 0; bus_addr = AW'(a);
    step();
    bus_sel = 0;
  endtask

  task automatic pulse(int m);
    int_evt = NI'(m);
    step();
    int_evt = '0;
  endtask

  initial begin
    for (int i = 0; i < NS; i++) begin m_lvl[i] = '0; m_req[i] = 0; end
    for (int i = 0; i < NE; i++) begin m_pol[i] = 0; m_s1[i] = 0; m_s2[i] = 0; m_prev[i] = 0; end
    m_rd = '0;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 reset irq", int'(irq), 0);
    check("R9 reset irq_num", int'(irq_num), 0);
    check("R9 reset irq_lvl", int'(irq_lvl), 0);
    check("R9 reset rdata", int'(bus_rdata), 0);
    rst_n = 1;
    rd(3);
    check("R9 reset ctl", int'(bus_rdata), 0);

    // R1: level 0 keeps a pending source out
    gie = 1; cpu_ipl = 0;
    wr(3, 8'h00);
    pulse(6'b000001);
    check("R1 lvl0 disabled", int'(irq_num), 0);
    wr(3, 8'h0B);
    check("R1 lvl3 enabled", int'(irq_num), 3);
    // R2: write 0 clears, write 1 has no effect
    wr(3, 8'h03);
    check("R2 write0 clears", int'(irq_num), 0);
    wr(3, 8'h0B);
    check("R2 write1 no set", int'(irq_num), 0);
    // R2: event wins over a clearing write at the same edge
    int_evt = 6'b000001;
    wr(3, 8'h03);
    int_evt = '0;
    check("R2 event beats clear", int'(irq_num), 3);
    wr(3, 8'h0D);
    // R5 tie between sources 2 and 3 at level 5
    wr(4, 8'h0D);
    pulse(6'b000011);
    check("R5 tie lowest", int'(irq_num), 3);
    cpu_ipl = 4;
    @(negedge clk);
    check("R6 above ipl", int'(irq), 1);
    cpu_ipl = 5;
    #1;
    check("R6 equal ipl", int'(irq), 0);
    cpu_ipl = 4; gie = 0;
    #1;
    check("R6 gie low", int'(irq), 0);
    // R7 acknowledge reads
    rd(0);
    check("R7 ack word", int'(bus_rdata), 8'hA3);
    check("R7 ack clears", int'(irq_num), 4);
    rd(0);
    check("R7 ack second", int'(bus_rdata), 8'hA4);
    rd(0);
    check("R7 ack empty", int'(bus_rdata), 0);
    rd(4);
    check("R8 ctl read", int'(bus_rdata), 8'h05);
    rd(12);
    check("R8 out of range", int'(bus_rdata), 0);
    // R3 pin edge timing
    gie = 1; cpu_ipl = 0;
    wr(1, 8'h11);
    ext_pin[0] = 1;
    step(); step();
    check("R3 not yet", int'(irq), 0);
    step();
    check("R3 flag raised", int'(irq_num), 1);
    // R4 polarity side effect
    wr(1, 8'h11);
    wr(1, 8'h01);
    rd(1);
    check("R4 no side effect", int'(bus_rdata), 8'h01);
    wr(1, 8'h11);
    rd(1);
    check("R4 spurious set", int'(bus_rdata), 8'h19);

    // random phase
    for (int c = 0; c < 3000; c++) begin
      int r;
      if ($urandom % 8 == 0) ext_pin[$urandom % NE] ^= 1'b1;
      int_evt = ($urandom % 4 == 0) ? NI'($urandom) & NI'($urandom) : '0;
      if ($urandom % 16 == 0) gie = $urandom % 4 != 0;
      if ($urandom % 16 == 0) cpu_ipl = 3'($urandom);
      r = $urandom % 8;
      bus_sel = 0; bus_wr = 0;
      if (r < 2) begin
        bus_sel = 1; bus_wr = 1; bus_addr = AW'(1 + $urandom % NS); bus_wdata = DW'($urandom);
      end else if (r < 4) begin
        bus_sel = 1; bus_wr = 0; bus_addr = AW'($urandom % 12);
      end
      step();
    end
    bus_sel = 0; int_evt = '0;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule